// File: doc/BRIEF.md
# Oscillator Settle Wait Timer

This block holds the core clock back for a programmable number of main-clock cycles after the chip leaves a low-power state. A STOP exit can come from reset or from an interrupt. In either case the oscillator has to start again, so the block arms itself and begins counting only once the oscillator reports that it is running. An IDLE exit leaves the oscillator running, so the same selected length is counted at once as a setup time. While the wait runs, the clock-enable output is low and the busy flag is high. On the terminal count both flip, and they stay that way until the next release event.

The wait length is always a power of two from 2^10 to 2^16 cycles. It is chosen by a 3-bit code in an 8-bit selection register on a simple register bus. The bus has a select from the address decode, a write strobe, write data and read data. Only the low three bits are storage. Code 7 is prohibited, and a write that carries it is dropped.

Top module: `osc_wait_timer`

## Requirements
- R1: While reset is asserted, and directly after it, the selection register reads 0x03, clk_en is 0 and busy is 1.
- R2: A write (reg_sel=1, reg_wr=1) whose bits 2:0 hold a code from 0 to 6 stores that code. Bits 7:3 of the write are discarded and always read back as 0.
- R3: A write whose bits 2:0 equal 3'b111 is ignored, and the stored code keeps its previous value.
- R4: reg_rdata is 0x00 whenever reg_sel is 0.
- R5: After an idle_rel pulse is sampled, clk_en stays 0 for exactly 2^(10+code) further clock edges. clk_en therefore first reads 1 after the (2^(10+code)+1)-th rising edge, counting the edge that sampled the pulse.
- R6: After reset release with osc_run high, the wait uses the default code 3. clk_en first reads 1 after rising edge 2^13+1 following release.
- R7: After reset release or a stop_rel_irq pulse, no cycle is counted while osc_run is 0. Once osc_run is 1, clk_en first reads 1 after rising edge 2^(10+code)+1 from the edge that sees osc_run high. A stop_rel_irq pulse sampled while osc_run is already high gives 2^(10+code)+2 edges.
- R8: A release event (stop_rel_irq or idle_rel) that arrives during a wait restarts the count from zero, and the full length is measured from the new event.
- R9: busy is always the inverse of clk_en. Once clk_en is 1, it stays 1 until the next release event.
- R10: The code in force when counting begins sets the length of that wait. A register write during a wait changes only later waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted synchronously to clk |
| reg_sel | input | 1 | Address decode hit for the selection register |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when not selected |
| stop_rel_irq | input | 1 | One-cycle pulse: STOP state left by an interrupt |
| idle_rel | input | 1 | One-cycle pulse: IDLE state left |
| osc_run | input | 1 | High once the main oscillator is oscillating |
| clk_en | output | 1 | Core clock enable, high when the wait is over |
| busy | output | 1 | High while a wait is armed or counting |

## Verification
The timed wait is measured, edge by edge, under four kinds of start. The first is an IDLE exit, where counting begins at once. The second is a STOP exit with the oscillator already up, which costs one extra arming edge. The third is a STOP exit with the oscillator held off for a while, which shows that idle cycles before oscillation are excluded. The fourth is reset release with the default code. Lengths for codes 0, 1, 2, 4 and 6 each give a different edge count, so a wrong exponent offset or a swapped code is exposed. Restarts during a wait and register writes during a wait tell a counter that reloads or relatches apart from one that runs on undisturbed.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;

  localparam int unsigned OSW_CODE_W = 3;

  typedef enum logic [1:0] {
    OSW_READY = 2'b00,
    OSW_ARMED = 2'b01,
    OSW_COUNT = 2'b10
  } osw_state_e;

endpackage

// File: rtl/osc_wait_selreg.sv
module osc_wait_selreg #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned NUM_CODES = 7,
  parameter int unsigned RST_CODE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned HI_W = DATA_W - CODE_W;

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              code_en;
  logic              code_legal;
  logic              unused_hi;

  // upper write bits carry no storage
  assign unused_hi  = &{1'b0, wdata_i[DATA_W-1:CODE_W]};

  assign code_legal = (32'(wdata_i[CODE_W-1:0]) < NUM_CODES);

  always_comb begin
    code_en = sel_i && wr_i && code_legal;
    code_d  = wdata_i[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_W'(RST_CODE);
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o = {{HI_W{1'b0}}, code_q};
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/osc_wait_cnt.sv
module osc_wait_cnt #(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned NUM_CODES = 7,
  parameter int unsigned MIN_EXP   = 10,
  parameter int unsigned RST_CODE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              lat_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              term_o
);

  localparam int unsigned MAX_EXP  = MIN_EXP + NUM_CODES - 1;
  localparam int unsigned CNT_W    = MAX_EXP;
  localparam int unsigned NUM_SLOT = 1 << CODE_W;

  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_d;
  logic                cnt_en;
  logic [CODE_W-1:0]   lat_q;
  logic [NUM_SLOT-1:0] hit;

  always_comb begin
    cnt_en = clr_i || inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= CODE_W'(RST_CODE);
    end else if (lat_i) begin
      lat_q <= code_i;
    end
  end

  // one terminal comparator per legal code; unused slots end at once
  for (genvar gi = 0; gi < NUM_SLOT; gi++) begin : g_term
    if (gi < NUM_CODES) begin : g_legal
      localparam int unsigned TV = (1 << (MIN_EXP + gi)) - 1;
      assign hit[gi] = (cnt_q == CNT_W'(TV));
    end else begin : g_void
      assign hit[gi] = 1'b1;
    end
  end

  assign term_o = hit[lat_q];

endmodule

// File: rtl/osc_wait_seq.sv
module osc_wait_seq
  import osc_wait_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_rel_i,
  input  logic idle_rel_i,
  input  logic osc_run_i,
  input  logic term_i,
  output logic clr_o,
  output logic inc_o,
  output logic lat_o,
  output logic clk_en_o,
  output logic busy_o
);

  osw_state_e st_q;
  osw_state_e st_d;

  always_comb begin
    st_d  = st_q;
    clr_o = 1'b0;
    inc_o = 1'b0;
    lat_o = 1'b0;
    if (stop_rel_i) begin
      // oscillator must restart: arm and wait for it
      st_d  = OSW_ARMED;
      clr_o = 1'b1;
    end else if (idle_rel_i) begin
      st_d  = OSW_COUNT;
      clr_o = 1'b1;
      lat_o = 1'b1;
    end else begin
      unique case (st_q)
        OSW_ARMED: begin
          if (osc_run_i) begin
            st_d  = OSW_COUNT;
            clr_o = 1'b1;
            lat_o = 1'b1;
          end
        end
        OSW_COUNT: begin
          if (term_i) begin
            st_d = OSW_READY;
          end else begin
            inc_o = 1'b1;
          end
        end
        default: st_d = OSW_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= OSW_ARMED;
    end else begin
      st_q <= st_d;
    end
  end

  assign clk_en_o = (st_q == OSW_READY);
  assign busy_o   = (st_q != OSW_READY);

endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_CODES = 7,
  parameter int unsigned MIN_EXP   = 10,
  parameter int unsigned RST_CODE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stop_rel_irq,
  input  logic              idle_rel,
  input  logic              osc_run,
  output logic              clk_en,
  output logic              busy
);

  localparam int unsigned CODE_W = osc_wait_pkg::OSW_CODE_W;

  logic [CODE_W-1:0] code_q;
  logic              cnt_clr;
  logic              cnt_inc;
  logic              cnt_lat;
  logic              cnt_term;

  osc_wait_selreg #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .NUM_CODES(NUM_CODES),
    .RST_CODE (RST_CODE)
  ) u_selreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (reg_sel),
    .wr_i   (reg_wr),
    .wdata_i(reg_wdata),
    .code_o (code_q),
    .rdata_o(reg_rdata)
  );

  osc_wait_cnt #(
    .CODE_W   (CODE_W),
    .NUM_CODES(NUM_CODES),
    .MIN_EXP  (MIN_EXP),
    .RST_CODE (RST_CODE)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .lat_i (cnt_lat),
    .code_i(code_q),
    .term_o(cnt_term)
  );

  osc_wait_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_rel_i(stop_rel_irq),
    .idle_rel_i(idle_rel),
    .osc_run_i (osc_run),
    .term_i    (cnt_term),
    .clr_o     (cnt_clr),
    .inc_o     (cnt_inc),
    .lat_o     (cnt_lat),
    .clk_en_o  (clk_en),
    .busy_o    (busy)
  );

endmodule

// File: rtl/osc_wait_timer_chk.sv
module osc_wait_timer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [2:0]        code_q,
  input logic              stop_rel_irq,
  input logic              idle_rel,
  input logic              clk_en,
  input logic              busy
);

  AST_HI_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[DATA_W-1:3] == '0)); // R2

  AST_WR_PROHIB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && (reg_wdata[2:0] == 3'b111)) |=> $stable(code_q)); // R3

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_q != 3'b111); // R3

  AST_UNSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata == '0)); // R4

  AST_EVENT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_rel_irq || idle_rel) |=> (busy && !clk_en)); // R8

  AST_EN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en != busy); // R9

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !stop_rel_irq && !idle_rel) |=> clk_en); // R9

endmodule

bind osc_wait_timer osc_wait_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .code_q      (code_q),
  .stop_rel_irq(stop_rel_irq),
  .idle_rel    (idle_rel),
  .clk_en      (clk_en),
  .busy        (busy)
);

// File: tb/osc_wait_timer_tb.sv
module osc_wait_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  typedef struct packed {
    logic [7:0] wdata;
    logic [2:0] exp_code;
    logic       do_wait;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{8'h00, 3'd0, 1'b1},
    '{8'hF9, 3'd1, 1'b1},
    '{8'h07, 3'd1, 1'b1},
    '{8'h02, 3'd2, 1'b1},
    '{8'hA4, 3'd4, 1'b1},
    '{8'h06, 3'd6, 1'b1},
    '{8'hFF, 3'd6, 1'b0},
    '{8'h00, 3'd0, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       reg_sel;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       stop_rel_irq;
  logic       idle_rel;
  logic       osc_run;
  logic       clk_en;
  logic       busy;

  int errors;
  int checks;
  bit done;

  osc_wait_timer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .stop_rel_irq(stop_rel_irq),
    .idle_rel    (idle_rel),
    .osc_run     (osc_run),
    .clk_en      (clk_en),
    .busy        (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    reg_sel   = 1'b1;
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // counts rising edges until clk_en reads 1; pulses drop after one edge
  task automatic wait_ready(output int n, output bit flag_ok);
    n = 0;
    flag_ok = 1'b1;
    do begin
      @(negedge clk);
      stop_rel_irq = 1'b0;
      idle_rel     = 1'b0;
      n++;
      if (busy == clk_en) flag_ok = 1'b0;
    end while (!clk_en && n < 70000);
  endtask

  task automatic pulse_idle();
    @(negedge clk);
    idle_rel = 1'b1;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WDOG_CYC, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit fok;
    errors = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; reg_sel = 1'b1; reg_wr = 1'b0; reg_wdata = '0;
    stop_rel_irq = 1'b0; idle_rel = 1'b0; osc_run = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_rdata == 8'h03, "R1 reset code", reg_rdata, 8'h03);
    check(!clk_en && busy, "R1 reset outputs", {clk_en, busy}, 1);
    // R6 default wait from reset release
    rst_n = 1'b1;
    wait_ready(n, fok);
    check(n == (1 << 13) + 1, "R6 default wait", n, (1 << 13) + 1);
    check(fok, "R9 busy inverse during wait", fok, 1);

    // R2 R3 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      reg_write(VEC[i].wdata);
      check(reg_rdata == {5'b0, VEC[i].exp_code}, "R2 R3 readback", reg_rdata, VEC[i].exp_code);
      if (VEC[i].do_wait) begin
        pulse_idle();
        wait_ready(n, fok);
        check(n == (1 << (10 + VEC[i].exp_code)) + 1, "R5 idle wait", n,
              (1 << (10 + VEC[i].exp_code)) + 1);
      end
    end

    // R4 unselected read
    @(negedge clk);
    reg_sel = 1'b0;
    #1;
    check(reg_rdata == 8'h00, "R4 unselected read", reg_rdata, 0);
    reg_sel = 1'b1;

    // R9 ready holds
    repeat (20) @(negedge clk);
    check(clk_en && !busy, "R9 ready holds", clk_en, 1);

    // R7 stop release with oscillator up: one arming edge
    @(negedge clk);
    stop_rel_irq = 1'b1;
    wait_ready(n, fok);
    check(n == 1024 + 2, "R7 stop osc up", n, 1024 + 2);

    // R7 stop release with oscillator held off
    @(negedge clk);
    osc_run = 1'b0;
    stop_rel_irq = 1'b1;
    @(negedge clk);
    stop_rel_irq = 1'b0;
    repeat (50) @(negedge clk);
    check(!clk_en && busy, "R7 armed while osc off", clk_en, 0);
    osc_run = 1'b1;
    wait_ready(n, fok);
    check(n == 1024 + 1, "R7 count after osc on", n, 1024 + 1);

    // R8 restart during wait
    pulse_idle();
    @(negedge clk);
    idle_rel = 1'b0;
    repeat (500) @(negedge clk);
    check(!clk_en, "R8 mid wait", clk_en, 0);
    pulse_idle();
    wait_ready(n, fok);
    check(n == 1024 + 1, "R8 restarted wait", n, 1024 + 1);

    // R10 write during wait does not alter current length
    pulse_idle();
    @(negedge clk);
    idle_rel = 1'b0;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_ready(n, fok);
    check(n + 2 == 1024 + 1, "R10 latched length", n + 2, 1024 + 1);
    check(reg_rdata == 8'h02, "R10 new code stored", reg_rdata, 2);

    // R1 R6 R7 reset with oscillator off
    @(negedge clk);
    osc_run = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(reg_rdata == 8'h03 && busy && !clk_en, "R1 re-reset state", reg_rdata, 3);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(busy && !clk_en, "R7 reset armed osc off", busy, 1);
    osc_run = 1'b1;
    wait_ready(n, fok);
    check(n == (1 << 13) + 1, "R6 R7 reset wait after osc", n, (1 << 13) + 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule